// File: doc/BRIEF.md
# One-Time-Programmable Register Array with Lock Control

This block holds a small array of one-time-programmable data words and the two lock words that protect it. A host issues commands: a data program, a lock program, a read, or a status clear. Each command carries a 9-bit word address and a 16-bit data word. Programming can only clear bits, because the stored value becomes the old value ANDed with the supplied data. The same rule applies to the lock words, so a segment cannot be unlocked once it has been locked.

Every program request is checked in three steps. The block first checks that the address falls in the right space. It then looks up the lock bit that covers the addressed word. Finally it either performs the write or records a failure in an 8-bit status word. The protection is uneven. The first 128-bit register is split into two 64-bit halves, and each half has its own lock bit in the first lock word. One of these two bits is already locked when reset ends. Each of the following 128-bit registers is guarded by one bit of the second lock word.

After every program command the block goes busy for a fixed number of cycles. While it is busy, the ready bit of the status word reads 0 and all commands are dropped.

Top module: `otp_lock_ctrl`

## Requirements
- R1: Reset state: status reads 0x80. Lock word 0 reads 0xFFFE, with bit 0 = 0 (locked). Lock word 1 reads 0xFFFF. Every data word reads 0xFFFF. A lock bit of 0 means locked.
- R2: A data program (cmd_type 0) to an unlocked data word stores old AND data. A later program with 1s in a position never raises that bit back to 1.
- R3: Address map. Data region 0 is words 0x081–0x088. Large register n (n = 1..NUM_BIG) is words 0x08A+8·(n−1) through 0x091+8·(n−1). A program changes only the addressed word.
- R4: A data program whose address is outside every data region sets status bit 4 (program error). Such addresses include 0x080, 0x089, anything below 0x081, and anything past the last large register. Bit 1 stays clear and no stored word changes.
- R5: A data program to a locked word sets status bits 4 and 1 and leaves the word unchanged. The locks are assigned as follows: words 0x081–0x084 by lock word 0 bit 0, words 0x085–0x088 by lock word 0 bit 1, and large register n by lock word 1 bit n−1.
- R6: A lock program (cmd_type 1) to word 0x080 or word 0x089 ANDs the data into that lock word. Writing 0xFFFD to 0x080 locks the upper half of region 0. A lock program to any other address sets status bit 4 only and changes nothing.
- R7: A lock bit that is 0 never returns to 1 under any command.
- R8: Status bits 4 and 1 stay set through later successful commands. Only a status clear (cmd_type 3) accepted while ready clears them.
- R9: After every accepted program command, successful or not, status bit 7 reads 0 for exactly BUSY_CYCLES cycles, starting in the cycle after the command.
- R10: While status bit 7 is 0, all commands are ignored. This covers programs, reads and clears.
- R11: A read (cmd_type 2) puts the addressed data or lock word on rd_data in the cycle after the command. Unmapped addresses read 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, sampled on the rising edge |
| cmd_type | input | 2 | 0 data program, 1 lock program, 2 read, 3 status clear |
| cmd_addr | input | 9 | Word address |
| cmd_data | input | 16 | Program data (AND mask) |
| rd_data | output | 16 | Registered read result |
| status | output | 8 | Bit 7 ready, bit 4 program error, bit 1 lock error, other bits 0 |

## Verification
The bench keeps the default of sixteen large registers, so the whole of the second lock word can be reached. This lets it exercise the very last data word at 0x109 and the first address past the array at 0x10A. It shortens the busy period to three cycles. That makes the exact width of the ready-low window easy to count. It also lets the bench drop a second program, a read and a clear into the middle of that window and show that each one is ignored.

// File: rtl/otp_pkg.sv
package otp_pkg;

    localparam int ADDR_W = 9;
    localparam int DATA_W = 16;
    localparam int SR_W   = 8;
    localparam int IDX_W  = 8;
    localparam int WPR    = 8;          // 16-bit words per 128-bit register
    localparam int HALF   = WPR / 2;    // words per 64-bit half

    localparam int LR0_ADDR  = 'h080;
    localparam int REG0_BASE = LR0_ADDR + 1;
    localparam int LR1_ADDR  = REG0_BASE + WPR;
    localparam int BIG_BASE  = LR1_ADDR + 1;

    localparam int SR_READY = 7;
    localparam int SR_PERR  = 4;
    localparam int SR_LERR  = 1;

    localparam logic [DATA_W-1:0] LR0_RESET = 16'hFFFE;
    localparam logic [DATA_W-1:0] LR1_RESET = 16'hFFFF;

    typedef enum logic [1:0] {
        CMD_OTP   = 2'd0,
        CMD_LOCK  = 2'd1,
        CMD_READ  = 2'd2,
        CMD_CLEAR = 2'd3
    } cmd_e;

    typedef struct packed {
        logic             in_data;
        logic             is_lr0;
        logic             is_lr1;
        logic             locked;
        logic [IDX_W-1:0] idx;
    } decode_t;

    function automatic int total_words(input int num_big);
        return WPR + num_big * WPR;
    endfunction

    function automatic int big_end(input int num_big);
        return BIG_BASE + num_big * WPR;
    endfunction

endpackage

// File: rtl/otp_decode.sv
module otp_decode
    import otp_pkg::*;
#(
    parameter int NUM_BIG = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] lr0,
    input  logic [DATA_W-1:0] lr1,
    output decode_t           dec
);

    localparam int END_ADDR = big_end(NUM_BIG);

    int a_int;
    int off0;
    int offb;
    logic [3:0] reg_n;

    always_comb begin
        a_int = int'(addr);
        off0  = a_int - REG0_BASE;
        offb  = a_int - BIG_BASE;
        reg_n = 4'(offb / WPR);
        dec   = '0;
        dec.is_lr0 = (a_int == LR0_ADDR);
        dec.is_lr1 = (a_int == LR1_ADDR);
        if (a_int >= REG0_BASE && a_int < LR1_ADDR) begin
            dec.in_data = 1'b1;
            dec.idx     = IDX_W'(off0);
            dec.locked  = (off0 < HALF) ? ~lr0[0] : ~lr0[1];
        end else if (a_int >= BIG_BASE && a_int < END_ADDR) begin
            dec.in_data = 1'b1;
            dec.idx     = IDX_W'(WPR + offb);
            dec.locked  = ~lr1[reg_n];
        end
    end

endmodule

// File: rtl/otp_store.sv
module otp_store
    import otp_pkg::*;
#(
    parameter int NUM_BIG = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  decode_t           dec,
    input  logic              wr_data_en,
    input  logic              wr_lr0,
    input  logic              wr_lr1,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] lr0,
    output logic [DATA_W-1:0] lr1,
    output logic [DATA_W-1:0] rd_data
);

    localparam int WORDS = total_words(NUM_BIG);

    logic [DATA_W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '1;
            lr0     <= LR0_RESET;
            lr1     <= LR1_RESET;
            rd_data <= '1;
        end else begin
            if (wr_data_en) mem[dec.idx] <= mem[dec.idx] & wdata;
            if (wr_lr0)     lr0 <= lr0 & wdata;
            if (wr_lr1)     lr1 <= lr1 & wdata;
            if (rd_en) begin
                if (dec.in_data)     rd_data <= mem[dec.idx];
                else if (dec.is_lr0) rd_data <= lr0;
                else if (dec.is_lr1) rd_data <= lr1;
                else                 rd_data <= '1;
            end
        end
    end

    // R5: the array is only ever written at an unlocked in-range word
    assert_no_locked_write_R5: assert property (@(posedge clk) disable iff (rst)
        wr_data_en |-> (dec.in_data && !dec.locked));

    // R7: lock bits move only from 1 to 0
    assert_lock_monotonic_R7: assert property (@(posedge clk) disable iff (rst)
        ((lr0 & ~$past(lr0)) == '0) && ((lr1 & ~$past(lr1)) == '0));

    // R1: the factory lock bit stays locked after reset
    assert_factory_lock_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !lr0[0]);

endmodule

// File: rtl/otp_status.sv
module otp_status
    import otp_pkg::*;
#(
    parameter int BUSY_CYCLES = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            prog_start,
    input  logic            set_perr,
    input  logic            set_lerr,
    input  logic            clear,
    output logic            ready,
    output logic [SR_W-1:0] status
);

    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

    logic [CNT_W-1:0] cnt;
    logic             perr;
    logic             lerr;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            perr <= 1'b0;
            lerr <= 1'b0;
        end else begin
            if (prog_start)     cnt <= CNT_W'(BUSY_CYCLES);
            else if (cnt != '0) cnt <= cnt - 1'b1;
            if (clear) begin
                perr <= 1'b0;
                lerr <= 1'b0;
            end
            if (set_perr) perr <= 1'b1;
            if (set_lerr) lerr <= 1'b1;
        end
    end

    assign ready = (cnt == '0);

    always_comb begin
        status           = '0;
        status[SR_READY] = ready;
        status[SR_PERR]  = perr;
        status[SR_LERR]  = lerr;
    end

    // R9: a program drops ready on the following cycle
    assert_busy_after_prog_R9: assert property (@(posedge clk) disable iff (rst)
        prog_start |=> !ready);

    // R9: the busy counter steps down by one each cycle
    assert_busy_countdown_R9: assert property (@(posedge clk) disable iff (rst)
        (cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

    // R10: nothing starts or clears while busy
    assert_busy_blocks_R10: assert property (@(posedge clk) disable iff (rst)
        !ready |-> (!prog_start && !clear));

    // R5: a lock error never appears without a program error
    assert_lerr_implies_perr_R5: assert property (@(posedge clk) disable iff (rst)
        status[SR_LERR] |-> status[SR_PERR]);

endmodule

// File: rtl/otp_lock_ctrl.sv
module otp_lock_ctrl
    import otp_pkg::*;
#(
    parameter int NUM_BIG     = 16,
    parameter int BUSY_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    input  logic [1:0]  cmd_type,
    input  logic [8:0]  cmd_addr,
    input  logic [15:0] cmd_data,
    output logic [15:0] rd_data,
    output logic [7:0]  status
);

    decode_t           dec;
    cmd_e              cmd;
    logic [DATA_W-1:0] lr0;
    logic [DATA_W-1:0] lr1;
    logic              ready;
    logic              accept;
    logic              is_otp;
    logic              is_lock;
    logic              wr_data_en;
    logic              wr_lr0;
    logic              wr_lr1;
    logic              rd_en;
    logic              clear;
    logic              prog_start;
    logic              set_perr;
    logic              set_lerr;

    otp_decode #(.NUM_BIG(NUM_BIG)) u_dec (
        .addr (cmd_addr),
        .lr0  (lr0),
        .lr1  (lr1),
        .dec  (dec)
    );

    always_comb begin
        cmd        = cmd_e'(cmd_type);
        accept     = cmd_valid && ready;
        is_otp     = accept && (cmd == CMD_OTP);
        is_lock    = accept && (cmd == CMD_LOCK);
        rd_en      = accept && (cmd == CMD_READ);
        clear      = accept && (cmd == CMD_CLEAR);
        wr_data_en = is_otp && dec.in_data && !dec.locked;
        wr_lr0     = is_lock && dec.is_lr0;
        wr_lr1     = is_lock && dec.is_lr1;
        prog_start = is_otp || is_lock;
        set_lerr   = is_otp && dec.in_data && dec.locked;
        set_perr   = (is_otp && (!dec.in_data || dec.locked)) ||
                     (is_lock && !(dec.is_lr0 || dec.is_lr1));
    end

    otp_store #(.NUM_BIG(NUM_BIG)) u_store (
        .clk        (clk),
        .rst        (rst),
        .dec        (dec),
        .wr_data_en (wr_data_en),
        .wr_lr0     (wr_lr0),
        .wr_lr1     (wr_lr1),
        .rd_en      (rd_en),
        .wdata      (cmd_data),
        .lr0        (lr0),
        .lr1        (lr1),
        .rd_data    (rd_data)
    );

    otp_status #(.BUSY_CYCLES(BUSY_CYCLES)) u_status (
        .clk        (clk),
        .rst        (rst),
        .prog_start (prog_start),
        .set_perr   (set_perr),
        .set_lerr   (set_lerr),
        .clear      (clear),
        .ready      (ready),
        .status     (status)
    );

    // R4: an out-of-range data program leaves the program-error bit set
    assert_range_error_R4: assert property (@(posedge clk) disable iff (rst)
        (is_otp && !dec.in_data) |=> status[SR_PERR]);

    // R6: a lock program to a non-lock address touches no lock word
    assert_lock_bad_addr_R6: assert property (@(posedge clk) disable iff (rst)
        (is_lock && !dec.is_lr0 && !dec.is_lr1) |=> ($stable(lr0) && $stable(lr1)));

endmodule

// File: tb/sim_otp_lock_ctrl.sv
module sim_otp_lock_ctrl;

    localparam int BUSY = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_type = 2'd0;
    logic [8:0]  cmd_addr = '0;
    logic [15:0] cmd_data = '0;
    logic [15:0] rd_data;
    logic [7:0]  status;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    otp_lock_ctrl #(.NUM_BIG(16), .BUSY_CYCLES(BUSY)) u0 (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_type  (cmd_type),
        .cmd_addr  (cmd_addr),
        .cmd_data  (cmd_data),
        .rd_data   (rd_data),
        .status    (status)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] t, input logic [8:0] a, input logic [15:0] d);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_type  = t;
        cmd_addr  = a;
        cmd_data  = d;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_ready();
        while (!status[7]) @(negedge clk);
    endtask

    task automatic prog(input logic [1:0] t, input logic [8:0] a, input logic [15:0] d);
        issue(t, a, d);
        wait_ready();
    endtask

    task automatic rd(input logic [8:0] a, output logic [15:0] v);
        issue(2'd2, a, 16'h0);
        v = rd_data;
    endtask

    task automatic clr();
        issue(2'd3, 9'h0, 16'h0);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        chk("R1 status", {8'h0, status}, 16'h0080);
        rd(9'h080, v); chk("R1 lock0", v, 16'hFFFE);
        rd(9'h089, v); chk("R1 lock1", v, 16'hFFFF);
        rd(9'h081, v); chk("R1 data", v, 16'hFFFF);
        rd(9'h109, v); chk("R1 last data", v, 16'hFFFF);
        rd(9'h000, v); chk("R11 unmapped low", v, 16'hFFFF);
        rd(9'h10A, v); chk("R11 unmapped high", v, 16'hFFFF);
    endtask

    task automatic t_and();
        logic [15:0] v;
        prog(2'd0, 9'h08A, 16'h1234);
        chk("R2 status", {8'h0, status}, 16'h0080);
        rd(9'h08A, v); chk("R2 first", v, 16'h1234);
        prog(2'd0, 9'h08A, 16'hFF00);
        rd(9'h08A, v); chk("R2 and", v, 16'h1200);
        prog(2'd0, 9'h08A, 16'hFFFF);
        rd(9'h08A, v); chk("R2 no raise", v, 16'h1200);
        rd(9'h08B, v); chk("R3 neighbour", v, 16'hFFFF);
        prog(2'd0, 9'h102, 16'h0F0F);
        rd(9'h102, v); chk("R3 reg16 first", v, 16'h0F0F);
        prog(2'd0, 9'h109, 16'hA5A5);
        rd(9'h109, v); chk("R3 reg16 last", v, 16'hA5A5);
        rd(9'h101, v); chk("R3 reg15 last", v, 16'hFFFF);
    endtask

    task automatic t_range();
        logic [15:0] v;
        logic [8:0] bad [6] = '{9'h000, 9'h07F, 9'h080, 9'h089, 9'h10A, 9'h1FF};
        foreach (bad[i]) begin
            clr();
            prog(2'd0, bad[i], 16'h0000);
            chk("R4 range status", {8'h0, status}, 16'h0090);
        end
        rd(9'h080, v); chk("R4 lock0 untouched", v, 16'hFFFE);
        rd(9'h089, v); chk("R4 lock1 untouched", v, 16'hFFFF);
    endtask

    task automatic t_factory();
        logic [15:0] v;
        clr();
        prog(2'd0, 9'h081, 16'h0000);
        chk("R5 low half status", {8'h0, status}, 16'h0092);
        rd(9'h081, v); chk("R5 low half data", v, 16'hFFFF);
        clr();
        prog(2'd0, 9'h084, 16'h0000);
        chk("R5 low half end", {8'h0, status}, 16'h0092);
        clr();
        prog(2'd0, 9'h085, 16'h00FF);
        chk("R5 upper half open", {8'h0, status}, 16'h0080);
        rd(9'h085, v); chk("R5 upper half data", v, 16'h00FF);
    endtask

    task automatic t_lock0();
        logic [15:0] v;
        prog(2'd1, 9'h080, 16'hFFFD);
        chk("R6 lock0 status", {8'h0, status}, 16'h0080);
        rd(9'h080, v); chk("R6 lock0 value", v, 16'hFFFC);
        prog(2'd0, 9'h085, 16'h0000);
        chk("R5 upper half locked", {8'h0, status}, 16'h0092);
        rd(9'h085, v); chk("R5 upper half kept", v, 16'h00FF);
    endtask

    task automatic t_lock1();
        logic [15:0] v;
        clr();
        prog(2'd1, 9'h089, 16'hFFFB);
        rd(9'h089, v); chk("R6 lock1 value", v, 16'hFFFB);
        prog(2'd0, 9'h09A, 16'h0000);
        chk("R5 reg3 first locked", {8'h0, status}, 16'h0092);
        clr();
        prog(2'd0, 9'h0A1, 16'h0000);
        chk("R5 reg3 last locked", {8'h0, status}, 16'h0092);
        rd(9'h09A, v); chk("R5 reg3 kept", v, 16'hFFFF);
        clr();
        prog(2'd0, 9'h092, 16'h5555);
        chk("R5 reg2 open", {8'h0, status}, 16'h0080);
        rd(9'h092, v); chk("R5 reg2 data", v, 16'h5555);
        prog(2'd0, 9'h0A2, 16'h1111);
        rd(9'h0A2, v); chk("R5 reg4 data", v, 16'h1111);
    endtask

    task automatic t_lock_bad();
        logic [15:0] v;
        clr();
        prog(2'd1, 9'h08A, 16'h0000);
        chk("R6 bad lock addr status", {8'h0, status}, 16'h0090);
        rd(9'h08A, v); chk("R6 bad lock addr data", v, 16'h1200);
        rd(9'h080, v); chk("R6 bad lock addr lock0", v, 16'hFFFC);
        rd(9'h089, v); chk("R6 bad lock addr lock1", v, 16'hFFFB);
    endtask

    task automatic t_never();
        logic [15:0] v;
        clr();
        prog(2'd1, 9'h080, 16'hFFFF);
        rd(9'h080, v); chk("R7 lock0 stays", v, 16'hFFFC);
        prog(2'd1, 9'h089, 16'hFFFF);
        rd(9'h089, v); chk("R7 lock1 stays", v, 16'hFFFB);
        chk("R7 status", {8'h0, status}, 16'h0080);
    endtask

    task automatic t_sticky();
        clr();
        prog(2'd0, 9'h000, 16'h0000);
        prog(2'd0, 9'h08C, 16'hFFF0);
        chk("R8 perr sticky", {8'h0, status}, 16'h0090);
        clr();
        chk("R8 clear perr", {8'h0, status}, 16'h0080);
        prog(2'd0, 9'h081, 16'h0000);
        prog(2'd0, 9'h08C, 16'hFF00);
        chk("R8 lerr sticky", {8'h0, status}, 16'h0092);
        clr();
        chk("R8 clear both", {8'h0, status}, 16'h0080);
    endtask

    task automatic t_busy();
        logic [15:0] v;
        int lows;
        issue(2'd0, 9'h08D, 16'h0000);
        lows = 0;
        while (!status[7] && lows < 50) begin
            lows++;
            @(negedge clk);
        end
        chk("R9 busy width", 16'(lows), 16'(BUSY));
        issue(2'd0, 9'h08E, 16'hAAAA);
        issue(2'd0, 9'h08F, 16'h0000);
        wait_ready();
        rd(9'h08E, v); chk("R10 first taken", v, 16'hAAAA);
        rd(9'h08F, v); chk("R10 busy prog ignored", v, 16'hFFFF);
        issue(2'd0, 9'h000, 16'h0000);
        issue(2'd3, 9'h000, 16'h0000);
        wait_ready();
        chk("R10 busy clear ignored", {8'h0, status}, 16'h0090);
        rd(9'h08E, v);
        issue(2'd0, 9'h001, 16'h0000);
        issue(2'd2, 9'h08D, 16'h0000);
        chk("R10 busy read ignored", rd_data, 16'hAAAA);
        wait_ready();
        clr();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_and();
        t_range();
        t_factory();
        t_lock0();
        t_lock1();
        t_lock_bad();
        t_never();
        t_sticky();
        t_busy();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

endmodule